// File: doc/BRIEF.md
# Task-Switch Local Table Selector Validator

During a hardware task switch, the incoming task supplies a selector for its local descriptor table. This block checks that selector and, when it is usable, loads the hidden base and limit of the local table from its descriptor in the global table. A request carries four values: the selector, the selector of the incoming task state segment, and the global table base and limit. The block first checks the selector against the global table. If that passes, it fetches the 8-byte descriptor through a request/response handshake and checks the descriptor's access byte.

Every request ends in exactly one of three outcomes. A null selector finishes quietly. A good descriptor produces a load strobe carrying its base and limit. A failure produces a task fault, which carries the task state segment selector and a cause code, together with a strobe telling the owner of the stored selector to zero it. The checks run in a fixed order: table and range, then type, then present. Only the first failing check is reported.

All three handshakes use valid/ready. A request is accepted only when `req_ready` is high, and `req_ready` is high only while the block is idle. Once raised, `fetch_valid` stays high with a stable `fetch_addr` until `fetch_ready` is seen. `resp_ready` is high only while the block waits for the descriptor. Response data is sampled only on the cycle where `resp_valid` and `resp_ready` are both high. Either side may stall for any number of cycles.

Top module: `ldtsel_loader`

## Requirements
- R1: `req_ready` is high only while no request is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low from the next cycle until the request finishes.
- R2: A selector with index 0 and table bit (bit 2) equal to 0 is null, whatever its privilege bits [1:0]. On the second edge counting the accepting edge, `fin` pulses without `load_en` and without `fault_valid`, and no fetch is issued.
- R3: A selector with table bit 1 gives a fault with cause 1 (outside table) on the second edge. No fetch is issued.
- R4: A selector with index (bits [15:3]) such that index*8+7 is greater than the global limit gives a fault with cause 1 on the second edge. No fetch is issued.
- R5: Otherwise `fetch_valid` rises on the second edge with `fetch_addr` = global base + index*8. Both hold unchanged until the edge where `fetch_ready` is high.
- R6: `resp_ready` is high from the edge after the fetch handshake until the response handshake, and low at all other times. Response inputs are ignored while `resp_valid` is low.
- R7: The descriptor must have access bit 4 = 0 and access bits [3:0] = 4'b0010. Otherwise a fault with cause 2 (wrong type) is raised on the response handshake edge.
- R8: A descriptor of the right type with access bit 7 = 0 gives a fault with cause 3 (not present). The type check takes priority over the present check.
- R9: A descriptor that passes both checks pulses `load_en` and `fin` on the response handshake edge, with `load_base` and `load_limit` equal to the response base and limit.
- R10: Every fault pulses `fault_valid`, `sel_clear` and `fin` together for one cycle, with `fault_sel` equal to the request's task state segment selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_ldt_sel | input | 16 | Local table selector to check |
| req_tss_sel | input | 16 | Incoming task state segment selector, reported on fault |
| req_gdt_base | input | ADDR_W | Global table base address |
| req_gdt_limit | input | GLIM_W | Global table limit (last valid byte offset) |
| fetch_valid | output | 1 | Descriptor fetch request |
| fetch_ready | input | 1 | Memory accepts the fetch |
| fetch_addr | output | ADDR_W | Address of the descriptor |
| resp_valid | input | 1 | Descriptor data present |
| resp_ready | output | 1 | Block waiting for descriptor data |
| resp_base | input | ADDR_W | Descriptor base |
| resp_limit | input | DLIM_W | Descriptor limit |
| resp_access | input | 8 | Descriptor access byte |
| fin | output | 1 | One-cycle pulse: request finished |
| load_en | output | 1 | One-cycle pulse: load hidden base and limit |
| load_base | output | ADDR_W | Base to load |
| load_limit | output | DLIM_W | Limit to load |
| sel_clear | output | 1 | One-cycle pulse: zero the stored selector |
| fault_valid | output | 1 | One-cycle pulse: task fault |
| fault_sel | output | 16 | Selector reported with the fault |
| fault_cause | output | 2 | 1 outside table, 2 wrong type, 3 not present |

## Verification
Null selectors and table or range faults finish on the second clock edge counting the accepting edge. A successful or failed descriptor check finishes on the edge of the response handshake itself. `fetch_valid` rises on the second edge, and `resp_ready` rises on the edge after the fetch handshake. The bench drives stimulus on falling edges and samples on the falling edge that follows each of these rising edges. It also checks that nothing finishes early while the memory side stalls for zero to two cycles on each handshake. Sweeps cover the table bit, privilege bits, indices and limits, and all 256 access bytes.

// File: rtl/ldt_pkg.sv
package ldt_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_RANGE  = 2'd1,
    CAUSE_TYPE   = 2'd2,
    CAUSE_ABSENT = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CHECK = 2'd1,
    PH_FETCH = 2'd2,
    PH_WAIT  = 2'd3
  } phase_e;

  localparam logic [3:0] LDT_SYS_TYPE = 4'b0010;
  localparam int ACC_PRESENT_BIT = 7;
  localparam int ACC_SEG_BIT     = 4;
  localparam int SEL_TI_BIT      = 2;
  localparam int SEL_W           = 16;
  localparam int IDX_W           = 13;
endpackage

// File: rtl/ldt_range_chk.sv
module ldt_range_chk
  import ldt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GLIM_W = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [GLIM_W-1:0] gdt_limit,
  output logic              is_null,
  output logic              out_of_range,
  output logic [ADDR_W-1:0] desc_addr
);
  localparam int CW = (GLIM_W > SEL_W) ? GLIM_W : SEL_W;

  logic [IDX_W-1:0] idx;
  logic             ti;
  logic [CW-1:0]    last_byte;
  logic [CW-1:0]    lim_ext;

  always_comb begin
    idx          = sel[SEL_W-1:3];
    ti           = sel[SEL_TI_BIT];
    last_byte    = CW'({idx, 3'b111});
    lim_ext      = CW'(gdt_limit);
    is_null      = (idx == '0) && !ti;
    out_of_range = ti || (last_byte > lim_ext);
    desc_addr    = gdt_base + ADDR_W'({idx, 3'b000});
  end
endmodule

// File: rtl/ldt_desc_chk.sv
module ldt_desc_chk
  import ldt_pkg::*;
(
  input  logic [7:0] access,
  output logic       ok,
  output cause_e     cause
);
  logic type_good;
  logic present;

  always_comb begin
    type_good = !access[ACC_SEG_BIT] && (access[3:0] == LDT_SYS_TYPE);
    present   = access[ACC_PRESENT_BIT];
    if (!type_good) begin
      cause = CAUSE_TYPE;
    end else if (!present) begin
      cause = CAUSE_ABSENT;
    end else begin
      cause = CAUSE_NONE;
    end
    ok = (cause == CAUSE_NONE);
  end
endmodule

// File: rtl/ldt_seq.sv
module ldt_seq
  import ldt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   is_null,
  input  logic   out_of_range,
  input  logic   fetch_ready,
  input  logic   resp_valid,
  output phase_e phase,
  output logic   req_fire,
  output logic   go_null,
  output logic   go_range,
  output logic   go_fetch,
  output logic   resp_fire
);
  phase_e phase_d;

  always_comb begin
    req_fire  = (phase == PH_IDLE) && req_valid;
    go_null   = (phase == PH_CHECK) && is_null;
    go_range  = (phase == PH_CHECK) && !is_null && out_of_range;
    go_fetch  = (phase == PH_CHECK) && !is_null && !out_of_range;
    resp_fire = (phase == PH_WAIT) && resp_valid;
    phase_d   = phase;
    unique case (phase)
      PH_IDLE:  if (req_fire) phase_d = PH_CHECK;
      PH_CHECK: phase_d = go_fetch ? PH_FETCH : PH_IDLE;
      PH_FETCH: if (fetch_ready) phase_d = PH_WAIT;
      PH_WAIT:  if (resp_fire) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phase_d;
    end
  end
endmodule

// File: rtl/ldtsel_loader.sv
module ldtsel_loader
  import ldt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GLIM_W = 16,
  parameter int DLIM_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_ldt_sel,
  input  logic [15:0]       req_tss_sel,
  input  logic [ADDR_W-1:0] req_gdt_base,
  input  logic [GLIM_W-1:0] req_gdt_limit,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              resp_valid,
  output logic              resp_ready,
  input  logic [ADDR_W-1:0] resp_base,
  input  logic [DLIM_W-1:0] resp_limit,
  input  logic [7:0]        resp_access,
  output logic              fin,
  output logic              load_en,
  output logic [ADDR_W-1:0] load_base,
  output logic [DLIM_W-1:0] load_limit,
  output logic              sel_clear,
  output logic              fault_valid,
  output logic [15:0]       fault_sel,
  output logic [1:0]        fault_cause
);
  logic [SEL_W-1:0]  sel_q;
  logic [SEL_W-1:0]  tss_q;
  logic [ADDR_W-1:0] base_q;
  logic [GLIM_W-1:0] glim_q;
  logic [ADDR_W-1:0] addr_q;

  logic              is_null, out_of_range;
  logic [ADDR_W-1:0] desc_addr;
  logic              desc_ok;
  cause_e            desc_cause;
  phase_e            phase;
  logic              req_fire, go_null, go_range, go_fetch, resp_fire;

  ldt_range_chk #(.ADDR_W(ADDR_W), .GLIM_W(GLIM_W)) u_range (
    .sel          (sel_q),
    .gdt_base     (base_q),
    .gdt_limit    (glim_q),
    .is_null      (is_null),
    .out_of_range (out_of_range),
    .desc_addr    (desc_addr)
  );

  ldt_desc_chk u_desc (
    .access (resp_access),
    .ok     (desc_ok),
    .cause  (desc_cause)
  );

  ldt_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .is_null      (is_null),
    .out_of_range (out_of_range),
    .fetch_ready  (fetch_ready),
    .resp_valid   (resp_valid),
    .phase        (phase),
    .req_fire     (req_fire),
    .go_null      (go_null),
    .go_range     (go_range),
    .go_fetch     (go_fetch),
    .resp_fire    (resp_fire)
  );

  assign req_ready   = (phase == PH_IDLE);
  assign fetch_valid = (phase == PH_FETCH);
  assign resp_ready  = (phase == PH_WAIT);
  assign fetch_addr  = addr_q;

  // request capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      tss_q  <= '0;
      base_q <= '0;
      glim_q <= '0;
      addr_q <= '0;
    end else begin
      if (req_fire) begin
        sel_q  <= req_ldt_sel;
        tss_q  <= req_tss_sel;
        base_q <= req_gdt_base;
        glim_q <= req_gdt_limit;
      end
      if (go_fetch) begin
        addr_q <= desc_addr;
      end
    end
  end

  // outcome strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fin         <= 1'b0;
      load_en     <= 1'b0;
      load_base   <= '0;
      load_limit  <= '0;
      sel_clear   <= 1'b0;
      fault_valid <= 1'b0;
      fault_sel   <= '0;
      fault_cause <= CAUSE_NONE;
    end else begin
      fin         <= go_null || go_range || resp_fire;
      load_en     <= resp_fire && desc_ok;
      sel_clear   <= go_range || (resp_fire && !desc_ok);
      fault_valid <= go_range || (resp_fire && !desc_ok);
      if (resp_fire && desc_ok) begin
        load_base  <= resp_base;
        load_limit <= resp_limit;
      end
      if (go_range) begin
        fault_sel   <= tss_q;
        fault_cause <= CAUSE_RANGE;
      end else if (resp_fire && !desc_ok) begin
        fault_sel   <= tss_q;
        fault_cause <= desc_cause;
      end
    end
  end
endmodule

// File: rtl/ldtsel_loader_chk.sv
module ldtsel_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       fetch_valid,
  input logic       fetch_ready,
  input logic [31:0] fetch_addr,
  input logic       resp_valid,
  input logic       resp_ready,
  input logic       fin,
  input logic       load_en,
  input logic       sel_clear,
  input logic       fault_valid,
  input logic [1:0] fault_cause
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!fetch_valid && !resp_ready));

  assert_fetch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

  assert_resp_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ready && !resp_valid) |=> resp_ready);

  assert_phase_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready |-> !fetch_valid);

  assert_null_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !load_en && !fault_valid) |-> !$past(resp_valid && resp_ready));

  assert_early_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_cause == 2'd1) |-> !$past(resp_valid && resp_ready));

  assert_late_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_cause != 2'd1) |-> $past(resp_valid && resp_ready));

  assert_load_after_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> ($past(resp_valid && resp_ready) && fin && !fault_valid));

  assert_fault_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (sel_clear && fin && fault_cause != 2'd0));
endmodule

bind ldtsel_loader ldtsel_loader_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .fetch_addr  (fetch_addr),
  .resp_valid  (resp_valid),
  .resp_ready  (resp_ready),
  .fin         (fin),
  .load_en     (load_en),
  .sel_clear   (sel_clear),
  .fault_valid (fault_valid),
  .fault_cause (fault_cause)
);

// File: tb/sim_ldtsel_loader.sv
`timescale 1ns/1ps
module sim_ldtsel_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_ldt_sel = '0;
  logic [15:0] req_tss_sel = '0;
  logic [31:0] req_gdt_base = '0;
  logic [15:0] req_gdt_limit = '0;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [31:0] fetch_addr;
  logic        resp_valid = 1'b0;
  logic        resp_ready;
  logic [31:0] resp_base = '0;
  logic [19:0] resp_limit = '0;
  logic [7:0]  resp_access = '0;
  logic        fin, load_en, sel_clear, fault_valid;
  logic [31:0] load_base;
  logic [19:0] load_limit;
  logic [15:0] fault_sel;
  logic [1:0]  fault_cause;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ldtsel_loader u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_ldt_sel(req_ldt_sel), .req_tss_sel(req_tss_sel),
    .req_gdt_base(req_gdt_base), .req_gdt_limit(req_gdt_limit),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_base(resp_base), .resp_limit(resp_limit), .resp_access(resp_access),
    .fin(fin), .load_en(load_en), .load_base(load_base), .load_limit(load_limit),
    .sel_clear(sel_clear), .fault_valid(fault_valid),
    .fault_sel(fault_sel), .fault_cause(fault_cause)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_one(input int idx, input bit ti, input int rpl, input int glim,
                         input int acc, input int d1, input int d2);
    logic [15:0] sel, tss;
    logic [31:0] gbase, dbase;
    logic [19:0] dlim;
    bit is_null, rng;
    int cause;
    sel   = {idx[12:0], ti, rpl[1:0]};
    tss   = {idx[7:0], 8'h3B};
    gbase = 32'h0040_0000 + 32'(idx) * 32'h10;
    dbase = 32'h1000_0000 + 32'(idx) * 32'h100 + 32'(acc);
    dlim  = 20'h00FFF ^ 20'(acc);
    is_null = (idx == 0) && !ti;
    rng     = !is_null && (ti || (idx * 8 + 7 > glim));
    if (acc[4] || acc[3:0] != 4'b0010) cause = 2;
    else if (!acc[7]) cause = 3;
    else cause = 0;

    req_valid = 1'b1; req_ldt_sel = sel; req_tss_sel = tss;
    req_gdt_base = gbase; req_gdt_limit = glim[15:0];
    chk(req_ready == 1'b1, "R1 ready when idle", 64'(req_ready), 1);
    tick();
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", 64'(req_ready), 0);
    chk(fin == 1'b0, "R2 no early finish", 64'(fin), 0);
    tick();
    if (is_null || rng) begin
      chk(fetch_valid == 1'b0, is_null ? "R2 no fetch" : "R4 no fetch", 64'(fetch_valid), 0);
      chk(fin == 1'b1, "R2 finish on second edge", 64'(fin), 1);
      chk(load_en == 1'b0, "R2 no load", 64'(load_en), 0);
      if (is_null) begin
        chk(fault_valid == 1'b0, "R2 null has no fault", 64'(fault_valid), 0);
      end else begin
        chk(fault_valid && fault_cause == 2'd1, ti ? "R3 table bit fault" : "R4 range fault",
            64'({fault_valid, fault_cause}), 64'({1'b1, 2'd1}));
        chk(sel_clear && fault_sel == tss, "R10 clear and selector",
            64'({sel_clear, fault_sel}), 64'({1'b1, tss}));
      end
    end else begin
      chk(fetch_valid && fetch_addr == gbase + 32'(idx) * 8, "R5 fetch address",
          64'({fetch_valid, fetch_addr}), 64'({1'b1, gbase + 32'(idx) * 8}));
      chk(resp_ready == 1'b0, "R6 no resp_ready during fetch", 64'(resp_ready), 0);
      for (int k = 0; k < d1; k++) begin
        tick();
        chk(fetch_valid && fetch_addr == gbase + 32'(idx) * 8, "R5 fetch held under stall",
            64'({fetch_valid, fetch_addr}), 64'({1'b1, gbase + 32'(idx) * 8}));
      end
      fetch_ready = 1'b1;
      tick();
      fetch_ready = 1'b0;
      chk(!fetch_valid && resp_ready, "R6 resp_ready after fetch",
          64'({fetch_valid, resp_ready}), 64'({1'b0, 1'b1}));
      for (int k = 0; k < d2; k++) begin
        resp_base = 32'hDEAD_BEEF; resp_limit = 20'h12345; resp_access = 8'h82;
        tick();
        chk(resp_ready && !fin && !load_en && !fault_valid, "R6 data ignored without valid",
            64'({resp_ready, fin, load_en, fault_valid}), 64'(4'b1000));
      end
      resp_valid = 1'b1; resp_base = dbase; resp_limit = dlim; resp_access = acc[7:0];
      tick();
      resp_valid = 1'b0; resp_base = '0; resp_limit = '0; resp_access = '0;
      chk(fin && !resp_ready, "R6 finish on response edge", 64'({fin, resp_ready}), 64'(2'b10));
      if (cause == 0) begin
        chk(load_en && !fault_valid && load_base == dbase && load_limit == dlim, "R9 load",
            {load_en, fault_valid, load_limit, load_base}, {1'b1, 1'b0, dlim, dbase});
      end else begin
        chk(fault_valid && !load_en && fault_cause == 2'(cause),
            cause == 2 ? "R7 type fault" : "R8 present fault",
            64'({fault_valid, load_en, fault_cause}), 64'({1'b1, 1'b0, 2'(cause)}));
        chk(sel_clear && fault_sel == tss, "R10 clear and selector",
            64'({sel_clear, fault_sel}), 64'({1'b1, tss}));
      end
    end
    tick();
    chk(!fin && !load_en && !fault_valid && !sel_clear, "R10 one-cycle strobes",
        64'({fin, load_en, fault_valid, sel_clear}), 0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    tick(); tick();
    chk(req_ready && !fetch_valid && !resp_ready && !fin && !load_en && !fault_valid && !sel_clear,
        "R1 reset state",
        64'({req_ready, fetch_valid, resp_ready, fin, load_en, fault_valid, sel_clear}),
        64'(7'b1000000));
    rst_n = 1'b1;
    tick();
    // selector sweep: table bit, privilege bits, index, limit
    for (int ti = 0; ti < 2; ti++)
      for (int li = 0; li < 3; li++)
        for (int idx = 0; idx < 16; idx++)
          run_one(idx, ti[0], (idx + li) % 4, (li == 0) ? 7 : (li == 1) ? 16'h27 : 16'h3F,
                  8'h82, idx % 3, (idx + ti) % 3);
    // access byte sweep
    for (int a = 0; a < 256; a++)
      run_one(2 + (a % 5), 1'b0, a % 4, 16'hFF, a, a % 3, (a / 3) % 3);
    // wide index against a large limit
    run_one(8191, 1'b0, 0, 16'hFFFF, 8'h82, 0, 0);
    run_one(8191, 1'b0, 0, 16'hFFFE, 8'h82, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule